// File: doc/BRIEF.md
# CAN Receive-Status Interrupt Controller

This block sits beside the receive path of a CAN controller. It takes receive-complete strobes that name a message buffer, error-state change pulses, an invalid-message pulse, a sleep indication and the raw receive pin. From these it keeps a full bit and an overflow bit for each message buffer and a set of sticky interrupt flags that software clears. It drives one combined interrupt line and a 7-bit code that names the pending source with the highest priority.

A strobe aimed at an empty buffer is a normal receive. A strobe aimed at a buffer that is already full is an overflow. The buffer's status bit is always updated one clock before the matching interrupt flag rises, so software that reacts to the flag always sees a consistent status bit. One contiguous range of buffers acts as a receive FIFO. A warning flag rises when a receive leaves exactly one free buffer in that range. While the device sleeps, a falling edge on the receive pin raises a wake-up flag.

The receive strobe is a plain one-cycle pulse. It is taken in every cycle and cannot be stalled, so the block applies no back-pressure. The producer may strobe on back-to-back cycles. All software inputs are write-one-to-clear pulses or level enables.

Top module: `can_rx_irq_ctrl`

## Requirements
- R1: Each of the NBUF buffers (32 by default) has its own full bit. A strobe on `rx_valid` to an empty buffer `rx_idx` sets that buffer's `buf_full` bit at the next clock edge.
- R2: The receive flag (`flags` bit 1) rises one cycle after the full bit, never in the same cycle. While it is the top pending source, `vec` equals the buffer number (0 to NBUF-1).
- R3: A strobe to a buffer that is already full leaves its full bit set and sets its `buf_ovf` bit at the next edge. The overflow flag (`flags` bit 2) rises one cycle later, and `vec` reports that buffer's number.
- R4: When a receive into the FIFO range FIFO_LO..FIFO_HI leaves exactly one free buffer in that range, the almost-full flag (`flags` bit 3) rises one cycle after the full bit. Its code is 0x43.
- R5: A pulse on any of the five `err_evt` bits sets the error flag (`flags` bit 5) at the next edge. The five bits are transmit warning, receive warning, transmit passive, receive passive and transmit bus-off. Its code is 0x41.
- R6: A falling edge on `rx_pin` passes through a two-flop synchronizer. It sets the wake-up flag (`flags` bit 6) only while `sleep` is high, and the wake-up code is 0x42. With `sleep` low, edges have no effect.
- R7: A pulse on `inv_evt` sets the invalid-message flag (`flags` bit 7) at the next edge. Its code is 0x44.
- R8: A flag stays set until a one is written to the same bit of `flag_clr`. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R9: A one in `full_clr` or `ovf_clr` frees the matching buffer's full or overflow bit. If a receive strobe arrives on the same cycle, its set wins over the clear. The overflow decision uses the full state from before the clear.
- R10: `vec` picks among the pending flags, whether or not they are enabled, in the order error, wake-up, overflow, receive, FIFO, invalid. With no flag pending it reads 0x40.
- R11: `irq` is high exactly when some flag is set and its `irq_en` bit is high. `flags` bits 0 and 4 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive-complete strobe, one cycle |
| rx_idx | input | $clog2(NBUF) | Target buffer of the strobe |
| err_evt | input | 5 | Error-state change pulses |
| inv_evt | input | 1 | Invalid message or transmission pulse |
| sleep | input | 1 | Device is in sleep mode |
| rx_pin | input | 1 | Raw CAN receive pin, asynchronous |
| full_clr | input | NBUF | Write-one-to-clear for full bits |
| ovf_clr | input | NBUF | Write-one-to-clear for overflow bits |
| flag_clr | input | 8 | Write-one-to-clear for interrupt flags |
| irq_en | input | 8 | Per-flag interrupt enables |
| buf_full | output | NBUF | Buffer full bits |
| buf_ovf | output | NBUF | Buffer overflow bits |
| flags | output | 8 | Interrupt flag register |
| irq | output | 1 | Combined interrupt line |
| vec | output | 7 | Code of the top-priority pending source |

## Verification
The bench builds the block with eight buffers and a four-buffer FIFO range covering buffers 4 to 7. With that size a sweep can fill every buffer in turn and then overflow each one. It also reaches the cycle where the FIFO has exactly one free buffer left, and the next cycle where it has none. The small size leaves room to step through all five error sources, the wake-up path with and without sleep, every priority pairing, and the same-cycle set-versus-clear collisions on flags and on buffer bits.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int FLAG_W  = 8;
  localparam int FB_RCV  = 1;
  localparam int FB_OVF  = 2;
  localparam int FB_FIFO = 3;
  localparam int FB_ERR  = 5;
  localparam int FB_WAKE = 6;
  localparam int FB_INV  = 7;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 8'b1110_1110;

  localparam logic [6:0] VEC_NONE = 7'h40;
  localparam logic [6:0] VEC_ERR  = 7'h41;
  localparam logic [6:0] VEC_WAKE = 7'h42;
  localparam logic [6:0] VEC_FIFO = 7'h43;
  localparam logic [6:0] VEC_INV  = 7'h44;

  typedef struct packed {
    logic rcv;
    logic ovf;
    logic fifo;
  } buf_evt_t;
endpackage

// File: rtl/can_buf_status.sv
module can_buf_status
  import can_irq_pkg::*;
#(
  parameter int NBUF    = 32,
  parameter int FIFO_LO = 24,
  parameter int FIFO_HI = 31,
  localparam int IW = $clog2(NBUF),
  localparam int CW = $clog2(NBUF + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [IW-1:0]   rx_idx,
  input  logic [NBUF-1:0] full_clr,
  input  logic [NBUF-1:0] ovf_clr,
  output logic [NBUF-1:0] full_q,
  output logic [NBUF-1:0] ovf_q,
  output buf_evt_t        evt_q,
  output logic [IW-1:0]   evt_idx_q
);
  logic [NBUF-1:0] sel, full_d, ovf_d;
  logic            was_full, in_rng;
  logic [CW-1:0]   free_cnt;
  buf_evt_t        evt_d;

  always_comb begin
    sel      = rx_valid ? ({{(NBUF-1){1'b0}}, 1'b1} << rx_idx) : '0;
    was_full = full_q[rx_idx];
    in_rng   = (int'(rx_idx) >= FIFO_LO) && (int'(rx_idx) <= FIFO_HI);
    // the receive strobe always keeps or sets its bit; a same-cycle clear loses
    full_d   = (full_q & ~full_clr) | sel;
    ovf_d    = (ovf_q & ~ovf_clr) | (was_full ? sel : '0);
    free_cnt = '0;
    for (int k = FIFO_LO; k <= FIFO_HI; k++) begin
      free_cnt = free_cnt + CW'(!full_d[k]);
    end
    evt_d.rcv  = rx_valid && !was_full;
    evt_d.ovf  = rx_valid && was_full;
    evt_d.fifo = rx_valid && !was_full && in_rng && (free_cnt == CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      ovf_q     <= '0;
      evt_q     <= '0;
      evt_idx_q <= '0;
    end else begin
      full_q    <= full_d;
      ovf_q     <= ovf_d;
      evt_q     <= evt_d;
      evt_idx_q <= rx_idx;
    end
  end

  a_r1_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !full_q[rx_idx] |=> full_q[$past(rx_idx)]);
  a_r3_ovf_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && full_q[rx_idx] |=> ovf_q[$past(rx_idx)] && full_q[$past(rx_idx)]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && full_clr[rx_idx] |=> full_q[$past(rx_idx)]);
endmodule

// File: rtl/can_wake_detect.sv
module can_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic sleep,
  output logic wake_pulse
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rx_pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign wake_pulse = sleep && s3_q && !s2_q;
endmodule

// File: rtl/can_vec_encode.sv
module can_vec_encode
  import can_irq_pkg::*;
#(
  parameter int NBUF = 32,
  localparam int IW = $clog2(NBUF)
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [IW-1:0]     rcv_idx,
  input  logic [IW-1:0]     ovf_idx,
  output logic [6:0]        vec
);
  always_comb begin
    if (flags[FB_ERR])       vec = VEC_ERR;
    else if (flags[FB_WAKE]) vec = VEC_WAKE;
    else if (flags[FB_OVF])  vec = 7'(ovf_idx);
    else if (flags[FB_RCV])  vec = 7'(rcv_idx);
    else if (flags[FB_FIFO]) vec = VEC_FIFO;
    else if (flags[FB_INV])  vec = VEC_INV;
    else                     vec = VEC_NONE;
  end
endmodule

// File: rtl/can_rx_irq_ctrl.sv
module can_rx_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int NBUF    = 32,
  parameter int FIFO_LO = 24,
  parameter int FIFO_HI = 31,
  localparam int IW = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [IW-1:0]     rx_idx,
  input  logic [4:0]        err_evt,
  input  logic              inv_evt,
  input  logic              sleep,
  input  logic              rx_pin,
  input  logic [NBUF-1:0]   full_clr,
  input  logic [NBUF-1:0]   ovf_clr,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [NBUF-1:0]   buf_full,
  output logic [NBUF-1:0]   buf_ovf,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic [6:0]        vec
);
  buf_evt_t          evt;
  logic [IW-1:0]     evt_idx, rcv_idx_q, ovf_idx_q;
  logic              wake_pulse;
  logic [FLAG_W-1:0] flags_q, flag_set;

  can_buf_status #(.NBUF(NBUF), .FIFO_LO(FIFO_LO), .FIFO_HI(FIFO_HI)) u_bufs (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_idx(rx_idx),
    .full_clr(full_clr), .ovf_clr(ovf_clr), .full_q(buf_full), .ovf_q(buf_ovf),
    .evt_q(evt), .evt_idx_q(evt_idx)
  );

  can_wake_detect u_wake (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .sleep(sleep), .wake_pulse(wake_pulse)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FB_RCV]  = evt.rcv;
    flag_set[FB_OVF]  = evt.ovf;
    flag_set[FB_FIFO] = evt.fifo;
    flag_set[FB_ERR]  = |err_evt;
    flag_set[FB_WAKE] = wake_pulse;
    flag_set[FB_INV]  = inv_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      rcv_idx_q <= '0;
      ovf_idx_q <= '0;
    end else begin
      flags_q <= ((flags_q & ~flag_clr) | flag_set) & FLAG_MASK;
      if (evt.rcv) rcv_idx_q <= evt_idx;
      if (evt.ovf) ovf_idx_q <= evt_idx;
    end
  end

  can_vec_encode #(.NBUF(NBUF)) u_vec (
    .flags(flags_q), .rcv_idx(rcv_idx_q), .ovf_idx(ovf_idx_q), .vec(vec)
  );

  assign flags = flags_q;
  assign irq   = |(flags_q & irq_en);

  a_r2_flag_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !buf_full[rx_idx] |=> !$past(flags_q[FB_RCV]) |-> ##1 flags_q[FB_RCV]);
  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && buf_full[rx_idx] |=> ##1 flags_q[FB_OVF]);
  a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != 5'd0) |=> flags_q[FB_ERR]);
  a_r6_wake_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FB_WAKE]) |-> $past(sleep));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~flag_clr)) == $past(flags_q & ~flag_clr)));
  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> (vec == VEC_NONE));
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);
endmodule

// File: tb/tb_can_rx_irq_ctrl.sv
`timescale 1ns/1ps
module tb_can_rx_irq_ctrl;
  localparam int NB = 8;
  localparam int LO = 4;
  localparam int HI = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [2:0] rx_idx = '0;
  logic [4:0] err_evt = '0;
  logic inv_evt = 1'b0;
  logic sleep = 1'b0;
  logic rx_pin = 1'b1;
  logic [NB-1:0] full_clr = '0;
  logic [NB-1:0] ovf_clr = '0;
  logic [7:0] flag_clr = '0;
  logic [7:0] irq_en = '0;
  logic [NB-1:0] buf_full, buf_ovf;
  logic [7:0] flags;
  logic irq;
  logic [6:0] vec;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [NB-1:0] m_full = '0;
  logic [NB-1:0] m_ovf = '0;

  always #2.5 clk = ~clk;

  can_rx_irq_ctrl #(.NBUF(NB), .FIFO_LO(LO), .FIFO_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_idx(rx_idx),
    .err_evt(err_evt), .inv_evt(inv_evt), .sleep(sleep), .rx_pin(rx_pin),
    .full_clr(full_clr), .ovf_clr(ovf_clr), .flag_clr(flag_clr), .irq_en(irq_en),
    .buf_full(buf_full), .buf_ovf(buf_ovf), .flags(flags), .irq(irq), .vec(vec)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_flags(logic [7:0] m);
    flag_clr = m; tick(); flag_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R10 reset vec", vec, 7'h40);
    check("R11 reset flags", flags, 8'h00);
    check("R11 reset irq", irq, 1'b0);
    check("R1 reset full", buf_full, '0);

    // fill every buffer, then overflow it
    for (int i = 0; i < NB; i++) begin
      int free;
      bit fexp;
      clear_flags(8'hFF);
      rx_valid = 1'b1; rx_idx = 3'(i); tick(); rx_valid = 1'b0;
      m_full[i] = 1'b1;
      free = 0;
      for (int k = LO; k <= HI; k++) free += (m_full[k] ? 0 : 1);
      fexp = (i >= LO) && (i <= HI) && (free == 1);
      check("R1 full bit set", buf_full, m_full);
      check("R2 flag not with full bit", flags[1], 1'b0);
      tick();
      check("R2 receive flag", flags[1], 1'b1);
      check("R2 vec index", vec, 7'(i));
      check("R4 fifo flag", flags[3], fexp);
      if (fexp) begin
        clear_flags(8'h02);
        check("R4 fifo code", vec, 7'h43);
      end
      rx_valid = 1'b1; rx_idx = 3'(i); tick(); rx_valid = 1'b0;
      m_ovf[i] = 1'b1;
      check("R3 ovf bit", buf_ovf, m_ovf);
      check("R3 full kept", buf_full, m_full);
      check("R3 flag not with ovf bit", flags[2], 1'b0);
      tick();
      check("R3 overflow flag", flags[2], 1'b1);
      check("R3 vec index", vec, 7'(i));
    end

    // free buffer 0, then receive into 0 and overflow 3: overflow outranks receive
    clear_flags(8'hFF);
    full_clr = 8'h01; tick(); full_clr = '0;
    m_full[0] = 1'b0;
    check("R9 full clear", buf_full, m_full);
    rx_valid = 1'b1; rx_idx = 3'd0; tick();
    rx_idx = 3'd3; tick(); rx_valid = 1'b0; tick();
    check("R10 ovf over rcv", vec, 7'd3);
    clear_flags(8'h04);
    check("R10 rcv after ovf cleared", vec, 7'd0);

    // clear racing a receive on a full buffer: set wins, counts as overflow
    clear_flags(8'hFF);
    full_clr = 8'h02; rx_valid = 1'b1; rx_idx = 3'd1; tick();
    full_clr = '0; rx_valid = 1'b0;
    check("R9 set wins full", buf_full[1], 1'b1);
    tick();
    check("R9 overflow on race", flags[2:1], 2'b10);
    ovf_clr = '1; tick(); ovf_clr = '0;
    check("R9 ovf clear", buf_ovf, '0);

    // each error source
    for (int k = 0; k < 5; k++) begin
      clear_flags(8'hFF);
      err_evt = 5'(1 << k); tick(); err_evt = '0;
      check("R5 error flag", flags[5], 1'b1);
      check("R5 error code", vec, 7'h41);
    end

    // wake-up ignored while awake
    clear_flags(8'hFF);
    rx_pin = 1'b0; repeat (5) tick();
    check("R6 no wake awake", flags[6], 1'b0);
    rx_pin = 1'b1; repeat (4) tick();
    sleep = 1'b1;
    err_evt = 5'b00001; tick(); err_evt = '0;
    rx_pin = 1'b0; repeat (4) tick();
    check("R6 wake flag", flags[6], 1'b1);
    check("R10 err over wake", vec, 7'h41);
    clear_flags(8'h20);
    check("R6 wake code", vec, 7'h42);
    sleep = 1'b0; rx_pin = 1'b1;

    // invalid message, set beats same-cycle clear, stickiness
    clear_flags(8'hFF);
    check("R10 none", vec, 7'h40);
    inv_evt = 1'b1; flag_clr = 8'h80; tick(); inv_evt = 1'b0; flag_clr = '0;
    check("R8 set wins flag", flags[7], 1'b1);
    check("R7 invalid code", vec, 7'h44);
    repeat (6) tick();
    check("R8 sticky", flags, 8'h80);

    // enables
    irq_en = 8'h7F; tick();
    check("R11 masked", irq, 1'b0);
    irq_en = 8'h80; tick();
    check("R11 enabled", irq, 1'b1);
    irq_en = 8'h11; clear_flags(8'hFF);
    check("R11 reserved bits", {flags[4], flags[0], irq}, 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule